// File: doc/BRIEF.md
# Maskable Interrupt Status Unit

This block collects the interrupt conditions of a serial peripheral that has a transmit FIFO and a receive FIFO, each `DEPTH` entries deep. Six sources feed a raw status vector. Two of them are level conditions computed from the FIFO occupancy and a programmable threshold. Four of them are sticky error flags set by events: a push into a full FIFO, a pop from an empty FIFO, or a bus contention pulse. A per-source mask forms the masked status, and a single active-high interrupt line is the OR of the masked bits.

A small register port reads and writes the mask and the two thresholds, and reads the raw and masked status. Five clear-on-read locations clear the sticky flags. Four of them each clear one flag, and one clears all four. Every read returns its data in `reg_rdata` on the clock edge that follows `reg_rd`. For clear locations, that data is the state of the flags before the clear.

Each sticky flag is a two-state machine, FLAG_IDLE and FLAG_PENDING:
- SET_EVT moves it from FLAG_IDLE to FLAG_PENDING when its event occurs.
- CLEAR_RD moves it back to FLAG_IDLE when a matching clear read occurs with no event in the same cycle.
- In every other case the state holds.

Top module: `isu_irq_unit`

## Requirements
- R1: Raw status bit 0 (TX low) is 1 exactly while `tx_level` is less than or equal to the TX threshold (register 1, bits 3:0). It is not sticky.
- R2: Raw status bit 4 (RX high) is 1 exactly while `rx_level` is greater than or equal to the RX threshold (register 2, bits 3:0) plus one. It is not sticky.
- R3: A `tx_push` while `tx_level` equals DEPTH sets raw bit 1. An `rx_push` while `rx_level` equals DEPTH sets raw bit 3. A push below DEPTH sets nothing. Both bits stay set until cleared.
- R4: An `rx_pop` while `rx_level` is 0 sets raw bit 2, which stays set until cleared.
- R5: A `contention` pulse sets raw bit 5, which stays set until cleared.
- R6: Register 0 holds the mask in bits 5:0. Register 3 reads the raw status and register 4 reads raw AND mask. `irq` is 1 exactly when the masked status is non-zero.
- R7: A read of register 5, 6, 7 or 8 clears only raw bit 1, 3, 2 or 5 respectively. The read returns that flag's value before the clear in `reg_rdata` bit 0, with all other bits 0.
- R8: A read of register 9 clears raw bits 1, 2, 3 and 5. It returns in bit 0 the OR of those four flags before the clear.
- R9: After reset the mask is 6'h3F, both thresholds are 0 and all sticky flags are 0.
- R10: When a flag's set event and its clear read fall in the same cycle, the flag ends up set.
- R11: Writes to registers 3 to 9 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_level | input | 5 | TX FIFO occupancy, 0 to DEPTH |
| rx_level | input | 5 | RX FIFO occupancy, 0 to DEPTH |
| tx_push | input | 1 | Push attempt into the TX FIFO |
| rx_push | input | 1 | Push attempt into the RX FIFO |
| rx_pop | input | 1 | Pop attempt from the RX FIFO |
| contention | input | 1 | Pulse marking a multi-master contention |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The level conditions are tried with a table of occupancy and threshold pairs. The table puts each level just on either side of its threshold and includes the empty and completely full extremes, which separates a less-or-equal comparison from a strict one and separates the plus-one RX offset from no offset. The same rows vary the mask, so a masked source that is still raised tells the raw view apart from the masked view and from `irq`. Directed sequences then raise each sticky flag, and clear the flags one by one and all at once. One sequence lands a clear read in the same cycle as its event, to show which of the two wins. Other sequences push below full and write read-only locations, to show that nothing changes.

// File: rtl/isu_pkg.sv
package isu_pkg;

    localparam int NSRC   = 6;
    localparam int NFLAG  = 4;
    localparam int ADDR_W = 4;

    // raw status bit positions
    localparam int B_TXLOW = 0;
    localparam int B_TXOVF = 1;
    localparam int B_RXUDF = 2;
    localparam int B_RXOVF = 3;
    localparam int B_RXHI  = 4;
    localparam int B_MST   = 5;

    // register indices
    localparam logic [ADDR_W-1:0] A_MASK    = 4'd0;
    localparam logic [ADDR_W-1:0] A_TXTH    = 4'd1;
    localparam logic [ADDR_W-1:0] A_RXTH    = 4'd2;
    localparam logic [ADDR_W-1:0] A_RAW     = 4'd3;
    localparam logic [ADDR_W-1:0] A_MASKED  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CLR_TXO = 4'd5;
    localparam logic [ADDR_W-1:0] A_CLR_RXO = 4'd6;
    localparam logic [ADDR_W-1:0] A_CLR_RXU = 4'd7;
    localparam logic [ADDR_W-1:0] A_CLR_MST = 4'd8;
    localparam logic [ADDR_W-1:0] A_CLR_ALL = 4'd9;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

endpackage

// File: rtl/isu_sticky_flag.sv
module isu_sticky_flag
    import isu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic pending
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:    if (set_evt) state_d = FLAG_PENDING;             // SET_EVT
            FLAG_PENDING: if (clr_req && !set_evt) state_d = FLAG_IDLE;    // CLEAR_RD, set wins
            default:      state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == FLAG_PENDING);
    end

endmodule

// File: rtl/isu_level_detect.sv
module isu_level_detect #(
    parameter int DEPTH = 16,
    parameter bit ABOVE = 1'b0,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int TH_W  = $clog2(DEPTH)
) (
    input  logic [LVL_W-1:0] level,
    input  logic [TH_W-1:0]  thresh,
    output logic             hit
);

    logic [LVL_W-1:0] th_ext;
    assign th_ext = LVL_W'(thresh);

    generate
        if (ABOVE) begin : g_above
            assign hit = (level >= th_ext + LVL_W'(1));
        end else begin : g_below
            assign hit = (level <= th_ext);
        end
    endgenerate

endmodule

// File: rtl/isu_regs.sv
module isu_regs
    import isu_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int TH_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [NSRC-1:0]   raw,
    output logic [NSRC-1:0]   mask,
    output logic [TH_W-1:0]   tx_th,
    output logic [TH_W-1:0]   rx_th,
    output logic [NFLAG-1:0]  clr,
    output logic [DATA_W-1:0] reg_rdata
);

    logic [DATA_W-1:0] rd_val;
    logic              all_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask  <= '1;
            tx_th <= '0;
            rx_th <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_MASK:  mask  <= reg_wdata[NSRC-1:0];
                A_TXTH:  tx_th <= reg_wdata[TH_W-1:0];
                A_RXTH:  rx_th <= reg_wdata[TH_W-1:0];
                default: ;
            endcase
        end
    end

    assign all_hit = reg_rd && (reg_addr == A_CLR_ALL);
    // flag index order: tx overflow, rx overflow, rx underflow, contention
    assign clr[0] = all_hit || (reg_rd && reg_addr == A_CLR_TXO);
    assign clr[1] = all_hit || (reg_rd && reg_addr == A_CLR_RXO);
    assign clr[2] = all_hit || (reg_rd && reg_addr == A_CLR_RXU);
    assign clr[3] = all_hit || (reg_rd && reg_addr == A_CLR_MST);

    always_comb begin
        rd_val = '0;
        case (reg_addr)
            A_MASK:    rd_val = DATA_W'(mask);
            A_TXTH:    rd_val = DATA_W'(tx_th);
            A_RXTH:    rd_val = DATA_W'(rx_th);
            A_RAW:     rd_val = DATA_W'(raw);
            A_MASKED:  rd_val = DATA_W'(raw & mask);
            A_CLR_TXO: rd_val = DATA_W'(raw[B_TXOVF]);
            A_CLR_RXO: rd_val = DATA_W'(raw[B_RXOVF]);
            A_CLR_RXU: rd_val = DATA_W'(raw[B_RXUDF]);
            A_CLR_MST: rd_val = DATA_W'(raw[B_MST]);
            A_CLR_ALL: rd_val = DATA_W'(raw[B_TXOVF] | raw[B_RXOVF] | raw[B_RXUDF] | raw[B_MST]);
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_val;
    end

endmodule

// File: rtl/isu_irq_unit.sv
module isu_irq_unit
    import isu_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int TH_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              tx_push,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic              contention,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    logic [NSRC-1:0]  raw_st;
    logic [NSRC-1:0]  mask;
    logic [TH_W-1:0]  tx_th;
    logic [TH_W-1:0]  rx_th;
    logic [NFLAG-1:0] clr;
    logic [NFLAG-1:0] set_evt;
    logic [NFLAG-1:0] pend;
    logic             tx_low;
    logic             rx_high;

    assign set_evt[0] = tx_push && (tx_level == FULL);
    assign set_evt[1] = rx_push && (rx_level == FULL);
    assign set_evt[2] = rx_pop  && (rx_level == '0);
    assign set_evt[3] = contention;

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            isu_sticky_flag u_flag (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_evt (set_evt[i]),
                .clr_req (clr[i]),
                .pending (pend[i])
            );
        end
    endgenerate

    isu_level_detect #(.DEPTH(DEPTH), .ABOVE(1'b0)) u_tx_low (
        .level  (tx_level),
        .thresh (tx_th),
        .hit    (tx_low)
    );

    isu_level_detect #(.DEPTH(DEPTH), .ABOVE(1'b1)) u_rx_high (
        .level  (rx_level),
        .thresh (rx_th),
        .hit    (rx_high)
    );

    always_comb begin
        raw_st          = '0;
        raw_st[B_TXLOW] = tx_low;
        raw_st[B_TXOVF] = pend[0];
        raw_st[B_RXUDF] = pend[2];
        raw_st[B_RXOVF] = pend[1];
        raw_st[B_RXHI]  = rx_high;
        raw_st[B_MST]   = pend[3];
    end

    isu_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .raw       (raw_st),
        .mask      (mask),
        .tx_th     (tx_th),
        .rx_th     (rx_th),
        .clr       (clr),
        .reg_rdata (reg_rdata)
    );

    assign irq = |(raw_st & mask);

endmodule

// File: rtl/isu_irq_chk.sv
module isu_irq_chk
    import isu_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   raw,
    input logic              irq,
    input logic [LVL_W-1:0]  tx_level,
    input logic [LVL_W-1:0]  rx_level,
    input logic              tx_push,
    input logic              rx_pop,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr
);

    // R3
    txo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_level == LVL_W'(DEPTH)) |=> raw[B_TXOVF]);

    // R4
    rxu_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_level == '0) |=> raw[B_RXUDF]);

    // R3
    txo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[B_TXOVF] && !(reg_rd && (reg_addr == A_CLR_TXO || reg_addr == A_CLR_ALL)))
        |=> raw[B_TXOVF]);

    // R8
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_CLR_ALL && !(tx_push && tx_level == LVL_W'(DEPTH)))
        |=> !raw[B_TXOVF]);

    // R6
    quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw == '0) |-> !irq);

endmodule

bind isu_irq_unit isu_irq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (raw_st),
    .irq      (irq),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_push  (tx_push),
    .rx_pop   (rx_pop),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr)
);

// File: tb/tb_isu_irq_unit.sv
`timescale 1ns/1ps
module tb_isu_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  tx_level = '0;
    logic [4:0]  rx_level = '0;
    logic        tx_push = 1'b0;
    logic        rx_push = 1'b0;
    logic        rx_pop = 1'b0;
    logic        contention = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] v;

    always #10 clk = ~clk;

    isu_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
        .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop), .contention(contention),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // {mask, tx_th, rx_th, tx_level, rx_level, expected raw, expected irq}
    localparam logic [30:0] VEC [8] = '{
        {6'h3F, 4'd0,  4'd0,  5'd0,  5'd0,  6'h01, 1'b1},
        {6'h3F, 4'd4,  4'd0,  5'd5,  5'd0,  6'h00, 1'b0},
        {6'h3F, 4'd4,  4'd0,  5'd4,  5'd1,  6'h11, 1'b1},
        {6'h3E, 4'd4,  4'd7,  5'd4,  5'd7,  6'h01, 1'b0},
        {6'h3E, 4'd4,  4'd7,  5'd4,  5'd8,  6'h11, 1'b1},
        {6'h2E, 4'd4,  4'd7,  5'd4,  5'd8,  6'h11, 1'b0},
        {6'h3F, 4'd15, 4'd15, 5'd16, 5'd16, 6'h10, 1'b1},
        {6'h3F, 4'd15, 4'd15, 5'd15, 5'd15, 6'h01, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        #1 d = reg_rdata;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        rd(4'd0, v); chk("R9 mask", v, 32'h3F);
        rd(4'd1, v); chk("R9 tx threshold", v, 32'h0);
        rd(4'd3, v); chk("R9 raw", v, 32'h01);
        chk("R9 irq", {31'b0, irq}, 32'h1);
        // R11 writes to read-only locations ignored
        wr(4'd3, 32'h3F); wr(4'd9, 32'hFF);
        rd(4'd3, v); chk("R11 raw after write", v, 32'h01);
        rd(4'd0, v); chk("R11 mask after write", v, 32'h3F);

        // R1 R2 R6 table
        for (int i = 0; i < 8; i++) begin
            wr(4'd0, {26'b0, VEC[i][30:25]});
            wr(4'd1, {28'b0, VEC[i][24:21]});
            wr(4'd2, {28'b0, VEC[i][20:17]});
            @(negedge clk);
            tx_level = VEC[i][16:12];
            rx_level = VEC[i][11:7];
            #1 chk("R6 irq vector", {31'b0, irq}, {31'b0, VEC[i][0]});
            rd(4'd3, v); chk("R1 R2 raw vector", v, {26'b0, VEC[i][6:1]});
            rd(4'd4, v); chk("R6 masked vector", v, {26'b0, VEC[i][6:1] & VEC[i][30:25]});
        end

        wr(4'd0, 32'h3F); wr(4'd1, 32'h0); wr(4'd2, 32'h0);
        @(negedge clk); tx_level = 5'd15; rx_level = 5'd0;
        // R3 push below full sets nothing
        tx_push = 1'b1; @(negedge clk); tx_push = 1'b0;
        rd(4'd3, v); chk("R3 no flag below full", v, 32'h00);
        @(negedge clk); tx_level = 5'd16;
        tx_push = 1'b1; @(negedge clk); tx_push = 1'b0;
        rd(4'd3, v); chk("R3 tx overflow", v, 32'h02);
        chk("R3 irq", {31'b0, irq}, 32'h1);
        // R4
        @(negedge clk); rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
        rd(4'd3, v); chk("R4 rx underflow", v, 32'h06);
        // R5
        @(negedge clk); contention = 1'b1; @(negedge clk); contention = 1'b0;
        rd(4'd3, v); chk("R5 contention", v, 32'h26);
        // R3 rx overflow
        @(negedge clk); rx_level = 5'd16; rx_push = 1'b1;
        @(negedge clk); rx_push = 1'b0; rx_level = 5'd0;
        rd(4'd3, v); chk("R3 rx overflow", v, 32'h2E);
        // R7 dedicated clears
        rd(4'd7, v); chk("R7 clear underflow data", v, 32'h1);
        rd(4'd3, v); chk("R7 only underflow cleared", v, 32'h2A);
        rd(4'd7, v); chk("R7 second clear data", v, 32'h0);
        rd(4'd5, v); chk("R7 clear tx overflow data", v, 32'h1);
        rd(4'd3, v); chk("R7 only tx overflow cleared", v, 32'h28);
        // R6 mask hides
        wr(4'd0, 32'h0);
        #1 chk("R6 masked irq", {31'b0, irq}, 32'h0);
        rd(4'd4, v); chk("R6 masked status zero", v, 32'h0);
        rd(4'd3, v); chk("R6 raw unaffected by mask", v, 32'h28);
        wr(4'd0, 32'h3F);
        // R8 global clear
        rd(4'd9, v); chk("R8 clear all data", v, 32'h1);
        rd(4'd3, v); chk("R8 all cleared", v, 32'h0);
        chk("R8 irq low", {31'b0, irq}, 32'h0);
        rd(4'd9, v); chk("R8 second clear data", v, 32'h0);
        // R10 set wins over clear in same cycle
        @(negedge clk); contention = 1'b1; reg_rd = 1'b1; reg_addr = 4'd8;
        @(negedge clk); contention = 1'b0; reg_rd = 1'b0;
        rd(4'd3, v); chk("R10 set wins", v, 32'h20);
        rd(4'd8, v); chk("R7 contention clear data", v, 32'h1);
        rd(4'd3, v); chk("R7 contention cleared", v, 32'h0);

        finish_run();
    end

endmodule